// File: doc/BRIEF.md
# Two-Stage Universal Flow Hasher

This block turns a 104-bit IPv4 flow key (addresses, ports and protocol) into three values for a flow counter table: a 32-bit flow ID, a table index and a 16-bit entry signature. The first stage is a tabulation hash. The key is cut into thirteen bytes. Each byte addresses its own 256-entry random table held in on-chip RAM, and the thirteen 32-bit words are XORed into the flow ID. The second stage applies a degree-4 polynomial modulo the Mersenne prime 2^61−1 to the flow ID, using Horner's rule over four pipeline stages. The low bits of that result form the table index. At the same time, a multiply-add hash modulo 2^32 gives the short signature that the table stores to tell apart the entries in a bucket.

The pipeline accepts one key per clock and has a fixed latency. A valid bit travels with each key. Software fills the random tables, the five polynomial coefficients and the two signature constants through a single write port. Parsing the packet header and accessing the counter table are handled outside this block.

Top module: `flow_hasher`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `out_flow_id`, `out_index` and `out_sig` are all 0.
- R2: A key accepted with `in_valid` high at clock edge k makes `out_valid` high for exactly the cycle that follows edge k+5. One key can be accepted on every edge, and idle cycles in the input appear unchanged in the output.
- R3: `out_flow_id` is the XOR of T_l[b_l] for l = 0..12, where b_l = `in_key[8l+7:8l]` (lane 0 is the least significant byte) and T_l is the 256-entry table of lane l.
- R4: `out_index` is the low 19 bits of h(x) = (a0 + a1·x + a2·x² + a3·x³ + a4·x⁴) mod (2^61−1), where x is the flow ID and a_i is coefficient register i. A coefficient equal to 2^61−1 behaves exactly like zero.
- R5: `out_sig` equals bits [31:16] of (m·x + c) mod 2^32, where m is the signature multiplier and c is the signature offset.
- R6: A write happens at a clock edge where `cfg_we` is high. When `cfg_kind` = 0, `cfg_data[31:0]` goes to entry `cfg_addr` of lane table `cfg_sel`. When `cfg_kind` = 1, `cfg_data[60:0]` goes to coefficient `cfg_sel`. When `cfg_kind` = 2, `cfg_data[31:0]` goes to the multiplier with bit 0 forced to 1. When `cfg_kind` = 3, `cfg_data[31:0]` goes to the offset.
- R7: A write whose `cfg_sel` is out of range changes no hash result. For `cfg_kind` 0 this means a lane of 13 or more. For `cfg_kind` 1 it means a coefficient of 5 or more.
- R8: While `out_valid` is 0, `out_flow_id`, `out_index` and `out_sig` keep the values of the last valid result.
- R9: After reset all coefficients are 0, the multiplier is 1 and the offset is 0. With this setup `out_index` is 0 and `out_sig` equals `out_flow_id[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key present this cycle |
| in_key | input | 104 | Flow key, lane l in bits [8l+7:8l] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 lane table, 1 coefficient, 2 multiplier, 3 offset |
| cfg_sel | input | 4 | Lane number or coefficient number |
| cfg_addr | input | 8 | Entry within a lane table |
| cfg_data | input | 61 | Write data |
| out_valid | output | 1 | Result present this cycle |
| out_flow_id | output | 32 | Tabulation hash of the key |
| out_index | output | 19 | Polynomial hash, low bits |
| out_sig | output | 16 | Entry signature |

## Verification
The assertions assume that configuration writes never overlap keys that are still in the pipeline. They also assume that a table entry is never written on the same edge at which a key reads it. With these assumptions the tables and coefficients are constant for the whole life of each key. The stimulus meets them by placing eight idle cycles between any group of writes and the next key. For the same reason, the expected values come from a shadow of the configuration that is updated when each write is driven. The sweeps step every byte value through every lane. They also drive corner coefficient sets in which every coefficient equals the prime, or equals the prime minus one.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;

  // A degree-4 polynomial needs five coefficients.
  localparam int unsigned NUM_COEF = 5;

  typedef enum logic [1:0] {
    CFG_TAB     = 2'd0,
    CFG_COEF    = 2'd1,
    CFG_SIG_MUL = 2'd2,
    CFG_SIG_ADD = 2'd3
  } cfg_kind_e;

endpackage

// File: rtl/lane_table_ram.sv
// One lane of the tabulation hash: a simple dual-port RAM with a registered
// read, written in a form that infers block RAM.
module lane_table_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tab_hash_stage.sv
// Tabulation stage. First edge: every lane RAM reads its entry. Second edge:
// the XOR of all lane words is registered as the flow ID.
module tab_hash_stage #(
  parameter int unsigned LANES  = 13,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ID_W   = 32,
  parameter int unsigned SEL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] key,
  input  logic                    tab_we,
  input  logic [SEL_W-1:0]        tab_lane,
  input  logic [LANE_W-1:0]       tab_addr,
  input  logic [ID_W-1:0]         tab_data,
  output logic                    fid_valid,
  output logic [ID_W-1:0]         fid
);

  logic [LANES-1:0]           lane_we;
  logic [LANES-1:0][ID_W-1:0] lane_word;
  logic                       rd_valid;
  logic [ID_W-1:0]            xor_all;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = tab_we && (tab_lane == SEL_W'(g));

    lane_table_ram #(
      .ADDR_W (LANE_W),
      .DATA_W (ID_W)
    ) u_ram (
      .clk   (clk),
      .we    (lane_we[g]),
      .waddr (tab_addr),
      .wdata (tab_data),
      .raddr (key[g*LANE_W +: LANE_W]),
      .rdata (lane_word[g])
    );
  end

  always_comb begin
    xor_all = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      xor_all = xor_all ^ lane_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      fid_valid <= 1'b0;
      fid       <= '0;
    end else begin
      rd_valid  <= in_valid;
      fid_valid <= rd_valid;
      if (rd_valid) begin
        fid <= xor_all;
      end
    end
  end

  // No more than one lane table accepts a given write.
  AST_ONE_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we)); // R7

endmodule

// File: rtl/sig_hash.sv
// Multiply-add hash: the upper bits of (m*x + c) mod 2^ID_W.
module sig_hash #(
  parameter int unsigned ID_W  = 32,
  parameter int unsigned SIG_W = 16
) (
  input  logic [ID_W-1:0]  x,
  input  logic [ID_W-1:0]  mul,
  input  logic [ID_W-1:0]  add,
  output logic [SIG_W-1:0] sig
);

  localparam int unsigned DROP = ID_W - SIG_W;

  logic [ID_W-1:0] lin;

  always_comb begin
    lin = mul * x + add;
    sig = SIG_W'(lin >> DROP);
  end

endmodule

// File: rtl/horner_step.sv
// One Horner step: acc_out = (acc_in * x + coef) mod (2^PRIME_W - 1).
// The reduction folds twice and ends with one conditional subtraction.
module horner_step #(
  parameter int unsigned ID_W    = 32,
  parameter int unsigned PRIME_W = 61,
  parameter int unsigned PASS_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PRIME_W-1:0] acc_in,
  input  logic [ID_W-1:0]    x_in,
  input  logic [PRIME_W-1:0] coef,
  input  logic [PASS_W-1:0]  pass_in,
  output logic               out_valid,
  output logic [PRIME_W-1:0] acc_out,
  output logic [ID_W-1:0]    x_out,
  output logic [PASS_W-1:0]  pass_out
);

  localparam int unsigned      PROD_W  = PRIME_W + ID_W + 1;
  localparam logic [PRIME_W:0] MODULUS = {1'b0, {PRIME_W{1'b1}}};

  logic [PROD_W-1:0]  prod_sum;
  logic [PRIME_W:0]   fold1;
  logic [PRIME_W:0]   fold2;
  logic [PRIME_W:0]   reduced;

  always_comb begin
    prod_sum = PROD_W'(acc_in) * PROD_W'(x_in) + PROD_W'(coef);
    fold1    = (PRIME_W+1)'(prod_sum[PRIME_W-1:0])
             + (PRIME_W+1)'(prod_sum[PROD_W-1:PRIME_W]);
    fold2    = (PRIME_W+1)'(fold1[PRIME_W-1:0]) + (PRIME_W+1)'(fold1[PRIME_W]);
    reduced  = (fold2 >= MODULUS) ? (fold2 - MODULUS) : fold2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      x_out     <= '0;
      pass_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out  <= reduced[PRIME_W-1:0];
        x_out    <= x_in;
        pass_out <= pass_in;
      end
    end
  end

  // Each accumulated value is a canonical residue.
  AST_RESIDUE_BELOW_PRIME: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, acc_out} < MODULUS)); // R4

endmodule

// File: rtl/flow_hasher.sv
module flow_hasher
  import flow_hash_pkg::*;
#(
  parameter  int unsigned LANES   = 13,
  parameter  int unsigned LANE_W  = 8,
  parameter  int unsigned ID_W    = 32,
  parameter  int unsigned IDX_W   = 19,
  parameter  int unsigned SIG_W   = 16,
  parameter  int unsigned PRIME_W = 61,
  localparam int unsigned KEY_W   = LANES * LANE_W,
  localparam int unsigned SEL_W   = ($clog2(LANES) > 3) ? $clog2(LANES) : 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [KEY_W-1:0]   in_key,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_kind,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [LANE_W-1:0]  cfg_addr,
  input  logic [PRIME_W-1:0] cfg_data,
  output logic               out_valid,
  output logic [ID_W-1:0]    out_flow_id,
  output logic [IDX_W-1:0]   out_index,
  output logic [SIG_W-1:0]   out_sig
);

  localparam int unsigned STAGES = NUM_COEF - 1;

  cfg_kind_e kind;
  assign kind = cfg_kind_e'(cfg_kind);

  // ---------------- configuration registers ----------------
  logic [PRIME_W-1:0] coef_q [NUM_COEF];
  logic [ID_W-1:0]    sig_mul_q;
  logic [ID_W-1:0]    sig_add_q;
  logic               coef_we;
  logic               tab_we;

  assign coef_we = cfg_we && (kind == CFG_COEF) && (cfg_sel < SEL_W'(NUM_COEF));
  assign tab_we  = cfg_we && (kind == CFG_TAB) && (cfg_sel < SEL_W'(LANES));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_COEF); i++) begin
        coef_q[i] <= '0;
      end
      sig_mul_q <= ID_W'(1);
      sig_add_q <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_COEF); i++) begin
        if (coef_we && (cfg_sel == SEL_W'(i))) begin
          coef_q[i] <= cfg_data;
        end
      end
      if (cfg_we && (kind == CFG_SIG_MUL)) begin
        sig_mul_q <= cfg_data[ID_W-1:0] | ID_W'(1);
      end
      if (cfg_we && (kind == CFG_SIG_ADD)) begin
        sig_add_q <= cfg_data[ID_W-1:0];
      end
    end
  end

  // ---------------- tabulation stage ----------------
  logic            fid_valid;
  logic [ID_W-1:0] fid;

  tab_hash_stage #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .ID_W   (ID_W),
    .SEL_W  (SEL_W)
  ) u_tab (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .key       (in_key),
    .tab_we    (tab_we),
    .tab_lane  (cfg_sel),
    .tab_addr  (cfg_addr),
    .tab_data  (cfg_data[ID_W-1:0]),
    .fid_valid (fid_valid),
    .fid       (fid)
  );

  // ---------------- signature ----------------
  logic [SIG_W-1:0] sig_now;

  sig_hash #(
    .ID_W  (ID_W),
    .SIG_W (SIG_W)
  ) u_sig (
    .x   (fid),
    .mul (sig_mul_q),
    .add (sig_add_q),
    .sig (sig_now)
  );

  // ---------------- polynomial stage ----------------
  logic [STAGES:0]              h_valid;
  logic [STAGES:0][PRIME_W-1:0] h_acc;
  logic [STAGES:0][ID_W-1:0]    h_x;
  logic [STAGES:0][SIG_W-1:0]   h_pass;

  assign h_valid[0] = fid_valid;
  assign h_acc[0]   = coef_q[NUM_COEF-1];
  assign h_x[0]     = fid;
  assign h_pass[0]  = sig_now;

  for (genvar s = 0; s < STAGES; s++) begin : g_horner
    horner_step #(
      .ID_W    (ID_W),
      .PRIME_W (PRIME_W),
      .PASS_W  (SIG_W)
    ) u_step (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (h_valid[s]),
      .acc_in    (h_acc[s]),
      .x_in      (h_x[s]),
      .coef      (coef_q[STAGES-1-s]),
      .pass_in   (h_pass[s]),
      .out_valid (h_valid[s+1]),
      .acc_out   (h_acc[s+1]),
      .x_out     (h_x[s+1]),
      .pass_out  (h_pass[s+1])
    );
  end

  assign out_valid   = h_valid[STAGES];
  assign out_flow_id = h_x[STAGES];
  assign out_index   = IDX_W'(h_acc[STAGES]);
  assign out_sig     = h_pass[STAGES];

  // ---------------- checks ----------------
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 6))); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable({out_flow_id, out_index, out_sig})); // R8

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef_chk
    AST_COEF_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && (kind == CFG_COEF) && (cfg_sel != SEL_W'(i)))
        |=> $stable(coef_q[i])); // R7
  end

endmodule

// File: tb/tb_flow_hasher.sv
module tb_flow_hasher;

  localparam int CLK_PERIOD = 10;
  localparam int LANES   = 13;
  localparam int LANE_W  = 8;
  localparam int ID_W    = 32;
  localparam int IDX_W   = 19;
  localparam int SIG_W   = 16;
  localparam int PRIME_W = 61;
  localparam int KEY_W   = LANES * LANE_W;
  localparam int HIST    = 6;
  localparam logic [127:0]     P128   = (128'd1 << 61) - 128'd1;
  localparam logic [PRIME_W-1:0] PRIME = {PRIME_W{1'b1}};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [KEY_W-1:0]   in_key = '0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_kind = 2'd0;
  logic [3:0]         cfg_sel = 4'd0;
  logic [LANE_W-1:0]  cfg_addr = '0;
  logic [PRIME_W-1:0] cfg_data = '0;
  logic               out_valid;
  logic [ID_W-1:0]    out_flow_id;
  logic [IDX_W-1:0]   out_index;
  logic [SIG_W-1:0]   out_sig;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_hasher dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_key      (in_key),
    .cfg_we      (cfg_we),
    .cfg_kind    (cfg_kind),
    .cfg_sel     (cfg_sel),
    .cfg_addr    (cfg_addr),
    .cfg_data    (cfg_data),
    .out_valid   (out_valid),
    .out_flow_id (out_flow_id),
    .out_index   (out_index),
    .out_sig     (out_sig)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // shadow configuration
  logic [PRIME_W-1:0] sh_coef [5];
  logic [31:0]        sh_mul = 32'd1;
  logic [31:0]        sh_add = 32'd0;

  // expected-result history, index HIST-1 is due now
  logic             hv   [HIST];
  logic [ID_W-1:0]  hid  [HIST];
  logic [IDX_W-1:0] hidx [HIST];
  logic [SIG_W-1:0] hsig [HIST];
  string            htag [HIST];
  logic [ID_W-1:0]  last_id  = '0;
  logic [IDX_W-1:0] last_idx = '0;
  logic [SIG_W-1:0] last_sig = '0;

  function automatic logic [31:0] tabv(int l, int a);
    logic [31:0] s;
    s = 32'(l * 256 + a + 1) * 32'h9E3779B1;
    return s ^ (s >> 13) ^ 32'(l << 24);
  endfunction

  function automatic logic [ID_W-1:0] fid_ref(logic [KEY_W-1:0] k);
    logic [ID_W-1:0] f = '0;
    for (int l = 0; l < LANES; l++) f ^= tabv(l, int'(k[l*8 +: 8]));
    return f;
  endfunction

  function automatic logic [IDX_W-1:0] idx_ref(logic [ID_W-1:0] x);
    logic [127:0] acc;
    acc = {67'd0, sh_coef[4]};
    for (int i = 3; i >= 0; i--) acc = (acc * {96'd0, x} + {67'd0, sh_coef[i]}) % P128;
    return acc[IDX_W-1:0];
  endfunction

  function automatic logic [SIG_W-1:0] sig_ref(logic [ID_W-1:0] x);
    logic [31:0] v;
    v = sh_mul * x + sh_add;
    return v[31:16];
  endfunction

  function automatic logic [KEY_W-1:0] mk_key(int i);
    logic [31:0] a, b, c;
    a = 32'(i + 1) * 32'h9E3779B1;
    b = (a ^ (a >> 16)) * 32'h85EBCA6B;
    c = (b ^ (b >> 13)) * 32'hC2B2AE35;
    return {a, b, c, b[7:0]};
  endfunction

  task automatic cmp(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [KEY_W-1:0] key,
                      input logic we, input logic [1:0] kind, input logic [3:0] sel,
                      input logic [7:0] addr, input logic [PRIME_W-1:0] data,
                      input string tag);
    @(negedge clk);
    cmp({"R2 out_valid ", htag[HIST-1]}, 64'(out_valid), 64'(hv[HIST-1]));
    if (hv[HIST-1]) begin
      cmp({"R3 flow id ", htag[HIST-1]}, 64'(out_flow_id), 64'(hid[HIST-1]));
      cmp({"R4 index ", htag[HIST-1]}, 64'(out_index), 64'(hidx[HIST-1]));
      cmp({"R5 signature ", htag[HIST-1]}, 64'(out_sig), 64'(hsig[HIST-1]));
      last_id  = hid[HIST-1];
      last_idx = hidx[HIST-1];
      last_sig = hsig[HIST-1];
    end else begin
      cmp("R8 hold flow id", 64'(out_flow_id), 64'(last_id));
      cmp("R8 hold index", 64'(out_index), 64'(last_idx));
      cmp("R8 hold signature", 64'(out_sig), 64'(last_sig));
    end
    for (int i = HIST-1; i > 0; i--) begin
      hv[i] = hv[i-1]; hid[i] = hid[i-1]; hidx[i] = hidx[i-1];
      hsig[i] = hsig[i-1]; htag[i] = htag[i-1];
    end
    hv[0] = iv;
    htag[0] = tag;
    if (iv) begin
      hid[0]  = fid_ref(key);
      hidx[0] = idx_ref(hid[0]);
      hsig[0] = sig_ref(hid[0]);
    end
    in_valid = iv;
    in_key   = key;
    cfg_we   = we;
    cfg_kind = kind;
    cfg_sel  = sel;
    cfg_addr = addr;
    cfg_data = data;
    if (we) begin
      case (kind)
        2'd1: if (sel < 4'd5) sh_coef[sel] = data;
        2'd2: sh_mul = data[31:0] | 32'd1;
        2'd3: sh_add = data[31:0];
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 2'd0, 4'd0, 8'd0, '0, "idle");
  endtask

  task automatic key_in(input logic [KEY_W-1:0] k, input string tag);
    step(1'b1, k, 1'b0, 2'd0, 4'd0, 8'd0, '0, tag);
  endtask

  task automatic set_coefs(input logic [PRIME_W-1:0] c0, input logic [PRIME_W-1:0] c1,
                           input logic [PRIME_W-1:0] c2, input logic [PRIME_W-1:0] c3,
                           input logic [PRIME_W-1:0] c4);
    step(1'b0, '0, 1'b1, 2'd1, 4'd0, 8'd0, c0, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd1, 8'd0, c1, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd2, 8'd0, c2, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd3, 8'd0, c3, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd4, 8'd0, c4, "cfg");
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < HIST; i++) begin
      hv[i] = 1'b0; hid[i] = '0; hidx[i] = '0; hsig[i] = '0; htag[i] = "none";
    end
    for (int i = 0; i < 5; i++) sh_coef[i] = '0;

    // R1: outputs cleared during reset
    repeat (4) begin
      @(negedge clk);
      cmp("R1 out_valid in reset", 64'(out_valid), 64'd0);
      cmp("R1 flow id in reset", 64'(out_flow_id), 64'd0);
      cmp("R1 index in reset", 64'(out_index), 64'd0);
      cmp("R1 signature in reset", 64'(out_sig), 64'd0);
    end
    rst = 1'b0;

    // R6: fill every lane table
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < 256; a++)
        step(1'b0, '0, 1'b1, 2'd0, 4'(l), 8'(a), PRIME_W'(tabv(l, a)), "cfg");
    idle(8);

    // R9: default coefficients and signature constants
    for (int i = 0; i < 64; i++) key_in(mk_key(i), "R9 default");
    key_in('0, "R9 zero key");
    idle(8);

    // R6: program coefficients and an even multiplier (bit 0 must be forced)
    set_coefs(61'h0123_4567_89AB_CDE, 61'h1F00_DEAD_BEEF_0001, 61'h0AAA_5555_AAAA_5555,
              61'h1234_0000_0000_4321, 61'h1ABC_DEF0_1234_5678);
    step(1'b0, '0, 1'b1, 2'd2, 4'd0, 8'd0, 61'h2545_F490, "cfg");
    step(1'b0, '0, 1'b1, 2'd3, 4'd0, 8'd0, 61'h1357_9BDF, "cfg");
    idle(8);
    for (int i = 0; i < 32; i++) key_in(mk_key(100 + i), "R6 programmed");
    idle(8);

    // R7: writes with out-of-range selectors must change nothing
    step(1'b0, '0, 1'b1, 2'd0, 4'd13, 8'h00, 61'h0FFF_FFFF, "cfg");
    step(1'b0, '0, 1'b1, 2'd0, 4'd15, 8'h3C, 61'h0BAD_BAD0, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd5, 8'h00, 61'h1555_5555_5555_5555, "cfg");
    step(1'b0, '0, 1'b1, 2'd1, 4'd7, 8'h00, 61'h0000_0000_0000_0001, "cfg");
    idle(8);
    key_in('0, "R7 zero key");
    for (int i = 0; i < 32; i++) key_in(mk_key(200 + i), "R7 after bad writes");

    // R3: every byte value through every lane, back to back
    for (int l = 0; l < LANES; l++)
      for (int v = 0; v < 256; v++)
        key_in(KEY_W'(v) << (8 * l), "R3 lane sweep");

    // R2 / R8: gapped stream
    for (int i = 0; i < 300; i++) begin
      if (((i * 7) % 5) < 2 || (i % 11) == 0)
        step(1'b0, '0, 1'b0, 2'd0, 4'd0, 8'd0, '0, "gap");
      else
        key_in(mk_key(500 + i), "R2 gapped");
    end
    idle(8);

    // R4: every coefficient equal to the prime behaves as zero
    set_coefs(PRIME, PRIME, PRIME, PRIME, PRIME);
    key_in('0, "R4 prime coefs");
    key_in({KEY_W{1'b1}}, "R4 prime coefs");
    for (int i = 0; i < 32; i++) key_in(mk_key(900 + i), "R4 prime coefs");
    idle(8);

    // R4: every coefficient at prime minus one
    set_coefs(PRIME - 1, PRIME - 1, PRIME - 1, PRIME - 1, PRIME - 1);
    key_in('0, "R4 max coefs");
    key_in({KEY_W{1'b1}}, "R4 max coefs");
    for (int i = 0; i < 64; i++) key_in(mk_key(1200 + i), "R4 max coefs");
    idle(10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule